// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block is the interrupt acceptance logic that sits beside one processor core. It keeps three 256-entry bit sets indexed by vector number: pending requests, vectors currently in service, and the trigger mode recorded for each vector. A higher vector number always means a higher priority. Vectors are grouped into classes of sixteen, and the class is the upper nibble of the vector. The block also holds a task-priority value and a spurious-vector register. Bit 8 of the spurious-vector register is the software enable.

Incoming vectors arrive with a trigger mode and are recorded as requests. The block raises its interrupt output when the highest pending request belongs to a class above the current processor priority. The processor priority is derived from the task priority and the highest vector in service. When the core acknowledges, the block returns a vector and moves it from the request set to the in-service set. If the acknowledge is masked, the block returns the spurious vector instead. An end-of-interrupt clears the highest in-service vector. A word-wide read port exposes the internal state.

Top module: `intr_prio_ctl`

## Requirements
- R1: After reset the request, in-service and trigger sets are all clear, the task priority is 0x00 and the spurious register reads 0x0FF, so the block starts disabled and `irq` is low.
- R2: A cycle with `acc_valid` high sets the request bit of `acc_vector`. The same cycle sets that vector's trigger bit when `acc_level` is 1 (level) and clears it when `acc_level` is 0 (edge).
- R3: A cycle with `tpr_wr` high loads the task priority with `{tpr_data, 4'h0}`.
- R4: A cycle with `svr_wr` high loads all 9 bits of `svr_data` into the spurious register. Bit 8 is the software enable, and bits 7:0 are the spurious vector.
- R5: The processor priority equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that in-service vector with its low nibble cleared. An empty in-service set counts as vector 0.
- R6: `irq` is high only when the block is enabled and a request is pending. It is held low when the processor priority is nonzero and the top request's upper nibble is not greater than the processor priority's upper nibble.
- R7: An acknowledge is granted when the block is enabled, a request is pending, and either the task priority is zero or the top request vector is greater than the task priority. On a granted acknowledge, `ack_vector` shows the highest pending vector, and at the clock edge that vector's request bit clears and its in-service bit sets.
- R8: An acknowledge that is not granted shows the spurious vector (spurious register bits 7:0) on `ack_vector` and leaves the request and in-service sets unchanged. This covers three cases: the block is disabled, no request is pending, or the top request is at or below the task priority.
- R9: `eoi` clears the highest set in-service bit. When no in-service bit is set, `eoi` changes nothing.
- R10: `rd_data` is combinational from `rd_index`. Index 0x08 reads the task priority, 0x0A reads the processor priority, and 0x0F reads the spurious register. Indices 0x10-0x17 read in-service words 0-7, 0x18-0x1F read trigger words 0-7, and 0x20-0x27 read request words 0-7. Bit b of word w is vector 32*w+b, and every other index reads zero.
- R11: When several operations land in one cycle, `eoi` acts on the in-service set as it stood before the edge, and the acknowledge's set of an in-service bit wins over an `eoi` clear of the same bit. An accept applies after the acknowledge's request clear, and task priority and spurious writes take effect only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Accept an incoming vector this cycle |
| acc_vector | input | 8 | Incoming vector number |
| acc_level | input | 1 | Trigger mode of the incoming vector: 1 level, 0 edge |
| tpr_wr | input | 1 | Write the task priority |
| tpr_data | input | 4 | Task priority class to write |
| svr_wr | input | 1 | Write the spurious register |
| svr_data | input | 9 | Enable bit and spurious vector |
| ack | input | 1 | Core acknowledges an interrupt this cycle |
| ack_vector | output | 8 | Vector returned for the acknowledge |
| eoi | input | 1 | End of interrupt |
| irq | output | 1 | Interrupt request to the core |
| rd_index | input | 8 | Register read index |
| rd_data | output | 32 | Register read data |

## Verification
The hardest situation to reach from the ports is a stack of nested in-service vectors in different classes combined with a task priority. In that state, the processor priority flips between the task-priority branch and the in-service branch as end-of-interrupts unwind the stack. The stimulus builds the stack on purpose: it accepts vectors from several classes, acknowledges them one by one as each higher one arrives, and moves the task priority above and below the in-service class. A long randomized phase then mixes accepts, acknowledges, end-of-interrupts and writes in the same cycles. Throughout, a behavioural model is compared against `irq`, `ack_vector` and a read index that sweeps every register on every clock.

// File: rtl/intr_prio_ctl.sv
`timescale 1ns/1ps
module intr_prio_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic [7:0]  acc_vector,
  input  logic        acc_level,
  input  logic        tpr_wr,
  input  logic [3:0]  tpr_data,
  input  logic        svr_wr,
  input  logic [8:0]  svr_data,
  input  logic        ack,
  output logic [7:0]  ack_vector,
  input  logic        eoi,
  output logic        irq,
  input  logic [7:0]  rd_index,
  output logic [31:0] rd_data
);
  localparam int VW = 8;
  localparam int NV = 1 << VW;

  logic [NV-1:0] req_q, svc_q, trig_q;
  logic [7:0]    tpr_q;
  logic [8:0]    svr_q;

  function automatic logic [VW:0] top_of(input logic [NV-1:0] v);
    logic [VW:0] r;
    r = '0;
    for (int i = 0; i < NV; i++)
      if (v[i]) r = {1'b1, VW'(i)};
    return r;
  endfunction

  logic [VW:0] req_top, svc_top;
  logic [7:0]  ppr;
  logic        en, grant;

  assign req_top = top_of(req_q);
  assign svc_top = top_of(svc_q);
  assign en      = svr_q[8];
  assign ppr     = (tpr_q[7:4] >= svc_top[7:4]) ? tpr_q : {svc_top[7:4], 4'h0};
  assign irq     = en && req_top[VW] && !(ppr != 8'h00 && req_top[7:4] <= ppr[7:4]);
  assign grant   = ack && en && req_top[VW] && !(tpr_q != 8'h00 && req_top[7:0] <= tpr_q);
  assign ack_vector = grant ? req_top[7:0] : svr_q[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      svc_q  <= '0;
      trig_q <= '0;
      tpr_q  <= '0;
      svr_q  <= 9'h0FF;
    end else begin
      if (eoi && svc_top[VW]) svc_q[svc_top[7:0]] <= 1'b0;
      if (grant) begin
        req_q[req_top[7:0]] <= 1'b0;
        svc_q[req_top[7:0]] <= 1'b1;
      end
      if (acc_valid) begin
        req_q[acc_vector]  <= 1'b1;
        trig_q[acc_vector] <= acc_level;
      end
      if (tpr_wr) tpr_q <= {tpr_data, 4'h0};
      if (svr_wr) svr_q <= svr_data;
    end
  end

  logic [7:0] word_base;
  assign word_base = {rd_index[2:0], 5'b0};

  always_comb begin
    rd_data = '0;
    if (rd_index == 8'h08)            rd_data = {24'h0, tpr_q};
    else if (rd_index == 8'h0A)       rd_data = {24'h0, ppr};
    else if (rd_index == 8'h0F)       rd_data = {23'h0, svr_q};
    else if (rd_index[7:3] == 5'h02)  rd_data = svc_q[word_base +: 32];
    else if (rd_index[7:3] == 5'h03)  rd_data = trig_q[word_base +: 32];
    else if (rd_index[7:3] == 5'h04)  rd_data = req_q[word_base +: 32];
  end

  // R2
  acc_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> req_q[$past(acc_vector)]);
  // R2
  acc_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> trig_q[$past(acc_vector)] == $past(acc_level));
  // R7
  grant_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> svc_q[$past(ack_vector)]);
  // R7
  grant_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !(acc_valid && acc_vector == ack_vector)) |=> !req_q[$past(ack_vector)]);
  // R8
  masked_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !grant && !acc_valid && !eoi) |=> (req_q == $past(req_q)) && (svc_q == $past(svc_q)));
  // R9
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !svc_top[VW] && !grant) |=> svc_q == $past(svc_q));
endmodule

// File: tb/intr_prio_ctl_bench.sv
`timescale 1ns/1ps
module intr_prio_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_level = 0, tpr_wr = 0, svr_wr = 0, ack = 0, eoi = 0;
  logic [7:0] acc_vector = 0, rd_index = 0;
  logic [3:0] tpr_data = 0;
  logic [8:0] svr_data = 0;
  logic [7:0] ack_vector;
  logic irq;
  logic [31:0] rd_data;

  always #2.5 clk = ~clk;

  intr_prio_ctl u_intr_prio_ctl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vector(acc_vector),
    .acc_level(acc_level), .tpr_wr(tpr_wr), .tpr_data(tpr_data), .svr_wr(svr_wr),
    .svr_data(svr_data), .ack(ack), .ack_vector(ack_vector), .eoi(eoi), .irq(irq),
    .rd_index(rd_index), .rd_data(rd_data));

  int total = 0, bad = 0, nstep = 0;
  bit done = 0;
  bit m_req[256], m_svc[256], m_trig[256];
  int m_tpr = 0, m_svr = 'h0FF;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int top_req();
    for (int i = 255; i >= 0; i--) if (m_req[i]) return i;
    return -1;
  endfunction
  function automatic int top_svc();
    for (int i = 255; i >= 0; i--) if (m_svc[i]) return i;
    return -1;
  endfunction
  function automatic int m_ppr();
    int s;
    s = top_svc();
    if (s < 0) s = 0;
    if ((m_tpr >> 4) >= (s >> 4)) return m_tpr;
    return (s >> 4) << 4;
  endfunction
  function automatic bit m_irq();
    int r, p;
    r = top_req(); p = m_ppr();
    if (!m_svr[8] || r < 0) return 0;
    if (p != 0 && (r >> 4) <= (p >> 4)) return 0;
    return 1;
  endfunction
  function automatic bit m_grant();
    int r;
    r = top_req();
    return ack && m_svr[8] && r >= 0 && !(m_tpr != 0 && r <= m_tpr);
  endfunction
  function automatic longint m_read(input int idx);
    longint w;
    w = 0;
    if (idx == 'h08) return m_tpr;
    if (idx == 'h0A) return m_ppr();
    if (idx == 'h0F) return m_svr;
    for (int b = 0; b < 32; b++) begin
      int v;
      v = (idx % 8) * 32 + b;
      if (idx >= 'h10 && idx <= 'h17 && m_svc[v]) w |= (64'd1 << b);
      if (idx >= 'h18 && idx <= 'h1F && m_trig[v]) w |= (64'd1 << b);
      if (idx >= 'h20 && idx <= 'h27 && m_req[v]) w |= (64'd1 << b);
    end
    return w;
  endfunction
  function automatic string rd_tag(input int idx);
    if (idx == 'h08) return "R3";
    if (idx == 'h0A) return "R5";
    if (idx == 'h0F) return "R4";
    if (idx >= 'h10 && idx <= 'h17) return "R9";
    if (idx >= 'h18 && idx <= 'h1F) return "R2";
    return "R10";
  endfunction

  task automatic step();
    int r, s;
    bit g;
    rd_index = 8'(nstep % 48);
    nstep++;
    #1;
    chk(irq == m_irq(), "R6", irq, m_irq());
    g = m_grant();
    r = top_req(); s = top_svc();
    if (ack) begin
      if (g) chk(ack_vector == 8'(r), "R7", ack_vector, r);
      else   chk(ack_vector == 8'(m_svr), "R8", ack_vector, m_svr & 'hFF);
    end
    chk(rd_data == 32'(m_read(rd_index)), rd_tag(rd_index), rd_data, m_read(rd_index));
    if (eoi && s >= 0) m_svc[s] = 0;
    if (g) begin m_req[r] = 0; m_svc[r] = 1; end
    if (acc_valid) begin m_req[acc_vector] = 1; m_trig[acc_vector] = acc_level; end
    if (tpr_wr) m_tpr = {tpr_data, 4'h0};
    if (svr_wr) m_svr = svr_data;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0; tpr_wr = 0; svr_wr = 0; ack = 0; eoi = 0;
  endtask

  task automatic accept(input int v, input bit lvl);
    acc_valid = 1; acc_vector = 8'(v); acc_level = lvl; step();
  endtask
  task automatic do_ack(); ack = 1; step(); endtask
  task automatic do_eoi(); eoi = 1; step(); endtask
  task automatic set_tpr(input int t); tpr_wr = 1; tpr_data = 4'(t); step(); endtask
  task automatic set_svr(input int v); svr_wr = 1; svr_data = 9'(v); step(); endtask
  task automatic read_chk(input int idx, input string tag);
    rd_index = 8'(idx); #1;
    chk(rd_data == 32'(m_read(idx)), tag, rd_data, m_read(idx));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rd_index = 8'h0F; #1; chk(rd_data == 32'h0FF, "R1", rd_data, 'h0FF);
    rd_index = 8'h08; #1; chk(rd_data == 0, "R1", rd_data, 0);
    rd_index = 8'h20; #1; chk(rd_data == 0, "R1", rd_data, 0);
    rd_index = 8'h17; #1; chk(rd_data == 0, "R1", rd_data, 0);
    chk(irq == 0, "R1", irq, 0);
    @(negedge clk);
    // disabled: request pending but no irq, ack spurious
    accept('h35, 0);
    do_ack();
    set_svr('h1E7);
    accept('h92, 1);
    accept('h41, 0);
    do_ack();                  // 0x92 into service
    accept('h9F, 1);           // same class: masked
    accept('hA0, 0);
    do_ack();                  // 0xA0 nested
    read_chk('h0A, "R5");
    do_eoi();
    read_chk('h15, "R9");
    set_tpr(5);
    do_ack();                  // 0x9F above 0x50
    set_tpr('hF);
    do_ack();                  // masked by task priority: spurious 0xE7
    read_chk('h22, "R8");
    do_eoi(); do_eoi(); do_eoi(); do_eoi();   // last ones on empty set
    set_tpr(0);
    accept(0, 1); accept(255, 0);
    do_ack(); do_ack(); do_ack(); do_ack(); do_ack();
    // R11: eoi, ack and accept together
    accept('h70, 0);
    accept('h60, 1);
    do_ack();
    eoi = 1; ack = 1; acc_valid = 1; acc_vector = 8'h60; acc_level = 0; step();
    read_chk('h23, "R11");
    read_chk('h13, "R11");
    read_chk('h1B, "R11");
    tpr_wr = 1; tpr_data = 4'h7; ack = 1; accept('h65, 1);
    read_chk('h08, "R11");
    set_svr('h0E7);
    do_ack();
    set_svr('h1E7);
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = int'($urandom_range(0, 99));
      acc_valid  = k < 35;
      acc_vector = 8'($urandom);
      acc_level  = 1'($urandom);
      ack        = ($urandom_range(0, 99)) < 25;
      eoi        = ($urandom_range(0, 99)) < 20;
      tpr_wr     = ($urandom_range(0, 99)) < 5;
      tpr_data   = 4'($urandom);
      svr_wr     = ($urandom_range(0, 99)) < 2;
      svr_data   = {($urandom_range(0, 9) != 0), 8'($urandom)};
      step();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule